// File: doc/BRIEF.md
# Debug-Port Code Security Controller

This block decides, cycle by cycle, whether requests from an external debug and emulation port may touch program memory or take over the processor. It watches the first processor cycles after a chip reset as a short window in which boot firmware may arm a sticky lock bit. Once armed, the lock admits only a whole-array flash erase from the debug port. Reads of code, writes and processor halt or control are all refused.

The lock can only be set. A write of zero is ignored, and so is a write of one once the window has closed. The only route back to an open port is to erase the whole flash and then reset the chip. The reset clears the lock, and the blank flash holds no code that could arm it again. Each request gets exactly one answer in the cycle it is presented: a grant or a deny. While a granted erase is still running, every further request is refused until the erase engine reports completion.

Top module: `dbg_sec_ctrl`

## Requirements
- R1: `boot_win` is high from reset until `PREBOOT_CYCLES` (default 32) `cpu_cyc` strobes have been taken, and it goes low on the clock edge that takes the last one. It stays low, whatever further strobes arrive, until the next reset.
- R2: While `boot_win` is high, every debug request of any kind is denied and `dbg_takeover` is low.
- R3: A synchronous reset clears `locked`, clears the erase-in-progress state and restarts the window.
- R4: A firmware write with `fw_lock_d` = 0 never clears `locked`; once set, `locked` stays high until reset.
- R5: `locked` is set on the edge after a firmware write with `fw_lock_d` = 1 is presented while `boot_win` is high. The same write after the window has closed has no effect.
- R6: While `locked` is high, only kind 3 (global erase) can be granted. Kinds 0 (read), 1 (write) and 2 (halt/control) are always denied.
- R7: With the window closed, `locked` low and no erase in progress, every request kind is granted and `dbg_takeover` is high.
- R8: `dbg_grant` and `dbg_deny` answer a request in the same cycle that `dbg_req` is high, and exactly one of them is high. Both are low when `dbg_req` is low.
- R9: After a granted kind-3 request, every request is denied until a cycle with `erase_done` high. `erase_done` does not change `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| cpu_cyc | input | 1 | One pulse per processor cycle |
| fw_lock_we | input | 1 | Firmware write strobe for the lock bit |
| fw_lock_d | input | 1 | Data written to the lock bit |
| dbg_req | input | 1 | Debug request present |
| dbg_kind | input | 2 | Request kind: 0 read, 1 write, 2 halt/control, 3 global erase |
| erase_done | input | 1 | Erase engine finished the global erase |
| boot_win | output | 1 | Preboot window status |
| locked | output | 1 | Lock bit value |
| dbg_grant | output | 1 | Request granted this cycle |
| dbg_deny | output | 1 | Request refused this cycle |
| dbg_takeover | output | 1 | Debug port may take control of the processor |

## Verification
The assertions assume that `rst` is held for at least one clock at start-up. They also assume that `dbg_kind` is a defined value whenever `dbg_req` is high, and that `erase_done` pulses only after an erase has been granted. The stimulus drives every input at the falling edge and always drives a valid kind with a request. It raises `erase_done` only after a granted erase, except for one deliberate stray pulse in the unlocked state, where it must have no effect. Reset is applied for several clocks at start-up and again in the middle of the run.

// File: rtl/dbg_sec_pkg.sv
package dbg_sec_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_HALT  = 2'd2,
    KIND_ERASE = 2'd3
  } dbg_kind_e;

  localparam int KIND_W = 2;
  localparam int KIND_N = 1 << KIND_W;
endpackage

// File: rtl/dbg_boot_window.sv
module dbg_boot_window #(
  parameter int PREBOOT_CYCLES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_cyc,
  output logic boot_win
);
  localparam int CW = $clog2(PREBOOT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PREBOOT_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          done;

  assign done = (cnt_q == LAST);

  // Saturating count of processor cycles since reset
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cpu_cyc && !done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign boot_win = !done;
endmodule

// File: rtl/dbg_lock_bit.sv
module dbg_lock_bit (
  input  logic clk,
  input  logic rst,
  input  logic boot_win,
  input  logic fw_lock_we,
  input  logic fw_lock_d,
  output logic locked
);
  logic lock_q;

  // Set-only: a zero write and any write after the window leave it alone
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
    end else if (fw_lock_we && fw_lock_d && boot_win) begin
      lock_q <= 1'b1;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/dbg_erase_track.sv
module dbg_erase_track (
  input  logic clk,
  input  logic rst,
  input  logic erase_start,
  input  logic erase_done,
  output logic erase_busy
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
    end else if (erase_start) begin
      busy_q <= 1'b1;
    end else if (erase_done) begin
      busy_q <= 1'b0;
    end
  end

  assign erase_busy = busy_q;
endmodule

// File: rtl/dbg_req_gate.sv
module dbg_req_gate
  import dbg_sec_pkg::*;
(
  input  logic              boot_win,
  input  logic              locked,
  input  logic              erase_busy,
  input  logic              dbg_req,
  input  logic [KIND_W-1:0] dbg_kind,
  output logic              dbg_grant,
  output logic              dbg_deny,
  output logic              erase_start
);
  logic [KIND_N-1:0] allow;

  // One permission line per request kind; only erase survives the lock
  for (genvar k = 0; k < KIND_N; k++) begin : g_kind
    if (k == int'(KIND_ERASE)) begin : g_erase
      assign allow[k] = !boot_win && !erase_busy;
    end else begin : g_other
      assign allow[k] = !boot_win && !erase_busy && !locked;
    end
  end

  assign dbg_grant   = dbg_req &&  allow[dbg_kind];
  assign dbg_deny    = dbg_req && !allow[dbg_kind];
  assign erase_start = dbg_grant && (dbg_kind == KIND_ERASE);
endmodule

// File: rtl/dbg_sec_ctrl.sv
module dbg_sec_ctrl
  import dbg_sec_pkg::*;
#(
  parameter int PREBOOT_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_cyc,
  input  logic              fw_lock_we,
  input  logic              fw_lock_d,
  input  logic              dbg_req,
  input  logic [KIND_W-1:0] dbg_kind,
  input  logic              erase_done,
  output logic              boot_win,
  output logic              locked,
  output logic              dbg_grant,
  output logic              dbg_deny,
  output logic              dbg_takeover
);
  logic erase_busy;
  logic erase_start;

  dbg_boot_window #(.PREBOOT_CYCLES(PREBOOT_CYCLES)) u_win (
    .clk      (clk),
    .rst      (rst),
    .cpu_cyc  (cpu_cyc),
    .boot_win (boot_win)
  );

  dbg_lock_bit u_lock (
    .clk        (clk),
    .rst        (rst),
    .boot_win   (boot_win),
    .fw_lock_we (fw_lock_we),
    .fw_lock_d  (fw_lock_d),
    .locked     (locked)
  );

  dbg_erase_track u_erase (
    .clk         (clk),
    .rst         (rst),
    .erase_start (erase_start),
    .erase_done  (erase_done),
    .erase_busy  (erase_busy)
  );

  dbg_req_gate u_gate (
    .boot_win    (boot_win),
    .locked      (locked),
    .erase_busy  (erase_busy),
    .dbg_req     (dbg_req),
    .dbg_kind    (dbg_kind),
    .dbg_grant   (dbg_grant),
    .dbg_deny    (dbg_deny),
    .erase_start (erase_start)
  );

  assign dbg_takeover = !boot_win && !locked;
endmodule

// File: rtl/dbg_sec_chk.sv
module dbg_sec_chk #(
  parameter int PREBOOT_CYCLES = 32
) (
  input logic       clk,
  input logic       rst,
  input logic       cpu_cyc,
  input logic       fw_lock_we,
  input logic       fw_lock_d,
  input logic       dbg_req,
  input logic [1:0] dbg_kind,
  input logic       boot_win,
  input logic       locked,
  input logic       dbg_grant,
  input logic       dbg_deny,
  input logic       dbg_takeover
);
  localparam int CW = $clog2(PREBOOT_CYCLES + 1) + 1;
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (cpu_cyc && seen < CW'(PREBOOT_CYCLES)) seen <= seen + 1'b1;
  end

  p_window_len_r1: assert property (@(posedge clk) disable iff (rst)
    boot_win == (seen < CW'(PREBOOT_CYCLES)));
  p_window_once_r1: assert property (@(posedge clk) disable iff (rst)
    !boot_win |=> !boot_win);
  p_boot_deny_r2: assert property (@(posedge clk) disable iff (rst)
    (boot_win && dbg_req) |-> (dbg_deny && !dbg_takeover));
  p_reset_clear_r3: assert property (@(posedge clk)
    $past(rst) |-> !locked);
  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
  p_lock_in_window_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(boot_win) && $past(fw_lock_we) && $past(fw_lock_d)));
  p_lock_erase_only_r6: assert property (@(posedge clk) disable iff (rst)
    (locked && dbg_grant) |-> (dbg_kind == 2'd3));
  p_takeover_open_r7: assert property (@(posedge clk) disable iff (rst)
    dbg_takeover |-> (!boot_win && !locked));
  p_one_answer_r8: assert property (@(posedge clk) disable iff (rst)
    dbg_req |-> $onehot({dbg_grant, dbg_deny}));
  p_no_answer_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !dbg_req |-> (!dbg_grant && !dbg_deny));
endmodule

bind dbg_sec_ctrl dbg_sec_chk #(.PREBOOT_CYCLES(PREBOOT_CYCLES)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_cyc      (cpu_cyc),
  .fw_lock_we   (fw_lock_we),
  .fw_lock_d    (fw_lock_d),
  .dbg_req      (dbg_req),
  .dbg_kind     (dbg_kind),
  .boot_win     (boot_win),
  .locked       (locked),
  .dbg_grant    (dbg_grant),
  .dbg_deny     (dbg_deny),
  .dbg_takeover (dbg_takeover)
);

// File: tb/test_dbg_sec_ctrl.sv
module test_dbg_sec_ctrl;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_cyc = 1'b0, fw_lock_we = 1'b0, fw_lock_d = 1'b0;
  logic dbg_req = 1'b0, erase_done = 1'b0;
  logic [1:0] dbg_kind = 2'd0;
  logic boot_win, locked, dbg_grant, dbg_deny, dbg_takeover;

  int checks = 0;
  int fails = 0;

  // reference model state
  int  m_cnt = 0;
  bit  m_lock = 1'b0;
  bit  m_busy = 1'b0;

  always #5 clk = ~clk;

  dbg_sec_ctrl #(.PREBOOT_CYCLES(N)) i_dbg_sec_ctrl (
    .clk(clk), .rst(rst), .cpu_cyc(cpu_cyc), .fw_lock_we(fw_lock_we),
    .fw_lock_d(fw_lock_d), .dbg_req(dbg_req), .dbg_kind(dbg_kind),
    .erase_done(erase_done), .boot_win(boot_win), .locked(locked),
    .dbg_grant(dbg_grant), .dbg_deny(dbg_deny), .dbg_takeover(dbg_takeover)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, compare against the model, then advance it
  task automatic step(input bit r, input bit cyc, input bit we, input bit wd,
                      input bit rq, input int kind, input bit done, input string tag);
    bit e_win, e_take, e_allow, e_grant, e_deny;
    @(negedge clk);
    rst = r; cpu_cyc = cyc; fw_lock_we = we; fw_lock_d = wd;
    dbg_req = rq; dbg_kind = 2'(kind); erase_done = done;
    #2;
    e_win   = (m_cnt < N);
    e_take  = !e_win && !m_lock;
    e_allow = !e_win && !m_busy && (!m_lock || kind == 3);
    e_grant = rq && e_allow;
    e_deny  = rq && !e_allow;
    if (!r) begin
      chk(boot_win == e_win, "R1 boot_win", boot_win, e_win);
      chk(locked == m_lock, "R4 locked", locked, m_lock);
      chk(dbg_takeover == e_take, "R7 takeover", dbg_takeover, e_take);
      chk(dbg_grant == e_grant, {tag, " grant"}, dbg_grant, e_grant);
      chk(dbg_deny == e_deny, {"R8 ", tag, " deny"}, dbg_deny, e_deny);
    end
    @(posedge clk);
    if (r) begin
      m_cnt = 0; m_lock = 1'b0; m_busy = 1'b0;
    end else begin
      if (we && wd && e_win) m_lock = 1'b1;
      if (e_grant && kind == 3) m_busy = 1'b1;
      else if (done) m_busy = 1'b0;
      if (cyc && m_cnt < N) m_cnt++;
    end
  endtask

  task automatic idle(input int n, input bit cyc);
    for (int i = 0; i < n; i++) step(0, cyc, 0, 0, 0, 0, 0, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 0, "R3");
    #3 chk(locked == 1'b0 && boot_win == 1'b1, "R3 reset state", locked, 0);
    // R2: every kind refused during the window, strobes intermittent
    for (int k = 0; k < 4; k++) step(0, k[0], 0, 0, 1, k, 0, "R2");
    // R4: a zero write is ignored; R5: a one write in the window sets the lock
    step(0, 1, 1, 0, 0, 0, 0, "R4");
    #3 chk(locked == 1'b0, "R4 zero write", locked, 0);
    step(0, 1, 1, 1, 0, 0, 0, "R5");
    #3 chk(locked == 1'b1, "R5 set in window", locked, 1);
    // close the window exactly, with a gap in strobes
    idle(5, 0);
    while (m_cnt < N) step(0, 1, 0, 0, 1, 0, 0, "R2");
    #3 chk(boot_win == 1'b0, "R1 window closed", boot_win, 0);
    idle(3, 1);
    // R6: only erase while locked, zero write cannot unlock
    for (int k = 0; k < 3; k++) step(0, 1, 0, 0, 1, k, 0, "R6");
    step(0, 0, 1, 0, 0, 0, 0, "R4");
    #3 chk(locked == 1'b1, "R4 sticky", locked, 1);
    step(0, 0, 0, 0, 1, 3, 0, "R6");
    // R9: refused while the erase runs, lock survives completion
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1, k, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, "R9");
    #3 chk(locked == 1'b1, "R9 lock kept", locked, 1);
    step(0, 0, 0, 0, 1, 3, 0, "R6");
    step(0, 0, 0, 0, 1, 3, 1, "R9");
    step(0, 0, 0, 0, 1, 1, 0, "R6");
    // R3: reset after erase reopens the port
    step(1, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, 0, 0, 0, "R3");
    #3 chk(locked == 1'b0 && boot_win == 1'b1, "R3 reset again", locked, 0);
    while (m_cnt < N) step(0, 1, 0, 0, 1, 2, 0, "R2");
    // R5: late write ignored
    step(0, 1, 1, 1, 0, 0, 0, "R5");
    #3 chk(locked == 1'b0, "R5 late write", locked, 0);
    // R7: all kinds granted, strobes keep the window shut
    for (int k = 0; k < 4; k++) step(0, 1, 0, 0, 1, k, 0, "R7");
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1, k, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, 0, 0, 1, "R9");
    for (int k = 0; k < 4; k++) step(0, 1, 0, 0, 1, k, 0, "R7");
    idle(40, 1);
    #3 chk(boot_win == 1'b0, "R1 stays low", boot_win, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule